// File: doc/BRIEF.md
# Transmit Disable DAC Sequencer

This block owns the two digital-to-analog code registers of a laser driver: the bias code and the modulation code. A hardware disable pin and a software disable bit are ORed into one effective disable. While it is active, both codes are forced to zero. When both sources are released, the block does not restore the old codes. The modulation code is taken from the temperature-indexed value that is present on its input at that moment. The bias code is then rebuilt by the same comparator-driven successive-approximation search that runs after the start-of-operation strobe.

The search starts with only the most significant bit set. An external comparator reports whether the resulting bias is at or below the set point. Each comparator-valid strobe resolves one bit, working down to the least significant bit, and a done flag is raised once the last bit is settled. The set points are already held on chip, so a re-enable starts the search on the next clock and does not wait for any power-up delay. A write strobe accompanies every change of each code, so that the driver's DAC port can be updated.

Top module: `txdis_dac_seq`

## Requirements
- R1: After reset both codes are 0, both write strobes are low and the done flag is low. The block stays in that state, and ignores comparator strobes, until a start strobe arrives.
- R2: The effective disable is the disable pin OR the soft-disable bit. In the clock after any cycle in which it is high, both codes read 0.
- R3: One clock after the effective disable is sampled low in the disabled state, the modulation code equals the temperature value sampled on that edge, and the bias code holds only its most significant bit (0x80 for 8 bits). No extra wait is inserted.
- R4: During a search, each cycle with comparator-valid high resolves the current trial bit: it stays 1 when the comparator input is 1 (at or below the set point) and is cleared when it is 0. The next lower bit is then set as the new trial. Over the full search the final bias code is the largest code that the comparator reports as at or below the set point.
- R5: In the clock after the least significant bit is resolved, the done flag is 1. While disable stays low, both codes then hold, and further comparator strobes and start strobes have no effect.
- R6: If disable rises during a search, the search is aborted. In the next clock both codes are 0 and the done flag is 0.
- R7: The bias write strobe is high in exactly those cycles in which the bias code shows a value different from the previous cycle. The modulation write strobe behaves the same way for the modulation code.
- R8: The done flag is 0 in the clock after any cycle in which disable is high.
- R9: A start strobe taken while disable is high leaves both codes at 0. The first release that follows then begins a search as in R3.
- R10: The temperature value is ignored except on the edge that loads it (R3). Changes to it while disabled or after the search leave the modulation code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_dis_pin | input | 1 | Hardware transmit-disable pin, 1 = disabled |
| tx_dis_soft | input | 1 | Software transmit-disable bit, 1 = disabled |
| start | input | 1 | Start-of-operation strobe |
| mod_temp | input | MOD_W | Modulation code for the present temperature |
| cmp_valid | input | 1 | Comparator result is valid this cycle |
| cmp_below | input | 1 | 1 = bias at or below the set point |
| bias_code | output | BIAS_W | Bias DAC code |
| mod_code | output | MOD_W | Modulation DAC code |
| bias_wr | output | 1 | Bias code changed this cycle |
| mod_wr | output | 1 | Modulation code changed this cycle |
| search_done | output | 1 | Bias search complete |

## Verification
Every result of this block is registered once. A disable, a release or a comparator strobe sampled on one rising edge shows on the codes, the strobes and the done flag straight after that edge. The bench drives inputs on the falling edge. Its driver queues the expected code pair, done flag and strobe pair for the falling edge that follows the effective rising edge, and the monitor pops and compares that item 1 ns after the falling edge. A full 8-bit search therefore costs eight strobe cycles. Its expected final code, and whether the last step changes the code, are derived from the target set point alone.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OFF    = 2'd1,
    ST_SEARCH = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/txseq_sar.sv
module txseq_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         step,
  input  logic         keep,
  output logic [W-1:0] code,
  output logic         last
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0]  TOP_ONLY = W'(1) << (W - 1);
  localparam logic [IW-1:0] TOP_IDX  = IW'(W - 1);

  logic [IW-1:0] idx_q;

  // resolve bit i, then place the next trial bit below it
  function automatic logic [W-1:0] sar_next(input logic [W-1:0] c,
                                            input logic [IW-1:0] i,
                                            input logic k);
    logic [W-1:0] r;
    r = c;
    if (!k) r[i] = 1'b0;
    if (i != '0) r[i - 1'b1] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      idx_q <= '0;
    end else if (clear) begin
      code  <= '0;
      idx_q <= TOP_IDX;
    end else if (load) begin
      code  <= TOP_ONLY;
      idx_q <= TOP_IDX;
    end else if (step) begin
      code <= sar_next(code, idx_q, keep);
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign last = (idx_q == '0);
endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dis,
  input  logic          start,
  input  logic          cmp_valid,
  input  logic          last,
  input  logic [MW-1:0] mod_temp,
  output logic          clear,
  output logic          load,
  output logic          step,
  output logic [MW-1:0] mod_code,
  output logic          done
);
  import txseq_pkg::*;

  seq_state_e st_q, st_d;

  assign clear = dis;
  assign load  = !dis && ((st_q == ST_IDLE && start) || st_q == ST_OFF);
  assign step  = !dis && (st_q == ST_SEARCH) && cmp_valid;

  always_comb begin
    st_d = st_q;
    if (dis) begin
      if (st_q != ST_IDLE || start) st_d = ST_OFF;
    end else if (load) begin
      st_d = ST_SEARCH;
    end else if (step && last) begin
      st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mod_code <= '0;
      done     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (dis) begin
        mod_code <= '0;
        done     <= 1'b0;
      end else if (load) begin
        mod_code <= mod_temp;
        done     <= 1'b0;
      end else if (step && last) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txseq_chg.sv
module txseq_chg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  output logic         wr
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= code;
  end

  assign wr = (code != prev_q);
endmodule

// File: rtl/txdis_dac_seq.sv
module txdis_dac_seq #(
  parameter int BIAS_W = 8,
  parameter int MOD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_dis_pin,
  input  logic              tx_dis_soft,
  input  logic              start,
  input  logic [MOD_W-1:0]  mod_temp,
  input  logic              cmp_valid,
  input  logic              cmp_below,
  output logic [BIAS_W-1:0] bias_code,
  output logic [MOD_W-1:0]  mod_code,
  output logic              bias_wr,
  output logic              mod_wr,
  output logic              search_done
);
  // named internal events, also seen by the bound checker
  logic dis_eff;
  logic clear_ev;
  logic load_ev;
  logic step_ev;
  logic last_bit;

  assign dis_eff = tx_dis_pin | tx_dis_soft;

  txseq_ctrl #(.MW(MOD_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dis      (dis_eff),
    .start    (start),
    .cmp_valid(cmp_valid),
    .last     (last_bit),
    .mod_temp (mod_temp),
    .clear    (clear_ev),
    .load     (load_ev),
    .step     (step_ev),
    .mod_code (mod_code),
    .done     (search_done)
  );

  txseq_sar #(.W(BIAS_W)) u_sar (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear_ev),
    .load (load_ev),
    .step (step_ev),
    .keep (cmp_below),
    .code (bias_code),
    .last (last_bit)
  );

  txseq_chg #(.W(BIAS_W)) u_bias_chg (
    .clk  (clk),
    .rst_n(rst_n),
    .code (bias_code),
    .wr   (bias_wr)
  );

  txseq_chg #(.W(MOD_W)) u_mod_chg (
    .clk  (clk),
    .rst_n(rst_n),
    .code (mod_code),
    .wr   (mod_wr)
  );
endmodule

// File: rtl/txseq_chk.sv
module txseq_chk #(
  parameter int BW = 8,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dis_eff,
  input logic          load_ev,
  input logic          step_ev,
  input logic [MW-1:0] mod_temp,
  input logic [BW-1:0] bias_code,
  input logic [MW-1:0] mod_code,
  input logic          bias_wr,
  input logic          mod_wr,
  input logic          search_done
);
  localparam logic [BW-1:0] TOP_ONLY = BW'(1) << (BW - 1);

  // R2, R6, R8
  p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_eff |=> (bias_code == '0 && mod_code == '0 && !search_done));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (bias_code == TOP_ONLY && mod_code == $past(mod_temp) && !search_done));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> ($countones(bias_code ^ $past(bias_code)) <= 2 && $stable(mod_code)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (search_done && !dis_eff) |=> ($stable(bias_code) && $stable(mod_code) && search_done));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !step_ev && !dis_eff) |=> (!bias_wr && !mod_wr));
endmodule

bind txdis_dac_seq txseq_chk #(.BW(BIAS_W), .MW(MOD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dis_eff    (dis_eff),
  .load_ev    (load_ev),
  .step_ev    (step_ev),
  .mod_temp   (mod_temp),
  .bias_code  (bias_code),
  .mod_code   (mod_code),
  .bias_wr    (bias_wr),
  .mod_wr     (mod_wr),
  .search_done(search_done)
);

// File: tb/test_txdis_dac_seq.sv
`timescale 1ns/1ps
module test_txdis_dac_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_dis_pin = 1'b0;
  logic       tx_dis_soft = 1'b0;
  logic       start = 1'b0;
  logic [7:0] mod_temp = 8'h00;
  logic       cmp_valid = 1'b0;
  logic       cmp_below = 1'b0;
  logic [7:0] bias_code;
  logic [7:0] mod_code;
  logic       bias_wr;
  logic       mod_wr;
  logic       search_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txdis_dac_seq #(.BIAS_W(8), .MOD_W(8)) i_txdis_dac_seq (
    .clk(clk), .rst_n(rst_n), .tx_dis_pin(tx_dis_pin), .tx_dis_soft(tx_dis_soft),
    .start(start), .mod_temp(mod_temp), .cmp_valid(cmp_valid), .cmp_below(cmp_below),
    .bias_code(bias_code), .mod_code(mod_code), .bias_wr(bias_wr), .mod_wr(mod_wr),
    .search_done(search_done)
  );

  typedef struct {
    string      req;
    logic [7:0] b;
    logic [7:0] m;
    logic       d;
    logic       bw;
    logic       mw;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;

  task automatic expect_now(input string req, input logic [7:0] b, input logic [7:0] m,
                            input logic d, input logic bw, input logic mw);
    exp_t x;
    x.req = req; x.b = b; x.m = m; x.d = d; x.bw = bw; x.mw = mw;
    exp_q.push_back(x);
  endtask

  // monitor: compares queued items shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_checks++;
      if (bias_code !== e.b || mod_code !== e.m || search_done !== e.d ||
          bias_wr !== e.bw || mod_wr !== e.mw) begin
        n_fails++;
        $display("FAIL %s: got bias=%h mod=%h done=%b bwr=%b mwr=%b, expected bias=%h mod=%h done=%b bwr=%b mwr=%b",
                 e.req, bias_code, mod_code, search_done, bias_wr, mod_wr,
                 e.b, e.m, e.d, e.bw, e.mw);
      end
    end
  end

  // comparator model: at or below the target set point
  task automatic sar_run(input logic [7:0] tgt, input int steps);
    for (int s = 0; s < steps; s++) begin
      @(negedge clk);
      cmp_below = (bias_code <= tgt);
      cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got run still busy, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 reset", 8'h00, 8'h00, 0, 0, 0);
    cmp_below = 1'b1; cmp_valid = 1'b1;
    repeat (2) @(negedge clk);
    cmp_valid = 1'b0;
    @(negedge clk);
    expect_now("R1 idle ignores strobes", 8'h00, 8'h00, 0, 0, 0);

    // R9: start while disabled
    tx_dis_pin = 1'b1; start = 1'b1; mod_temp = 8'h4C;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    expect_now("R9 start while disabled", 8'h00, 8'h00, 0, 0, 0);
    tx_dis_pin = 1'b0;
    @(negedge clk);
    expect_now("R3 first release", 8'h80, 8'h4C, 0, 1, 1);
    sar_run(8'hA5, 8);
    expect_now("R4 search A5", 8'hA5, 8'h4C, 1, 0, 0);

    // R5 / R10: strobes and temperature after done
    mod_temp = 8'h11; cmp_below = 1'b0; cmp_valid = 1'b1; start = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0; start = 1'b0;
    @(negedge clk);
    expect_now("R5 hold after done", 8'hA5, 8'h4C, 1, 0, 0);

    // R2 / R7 / R8: pin disable
    tx_dis_pin = 1'b1;
    @(negedge clk);
    expect_now("R2 pin zeroes codes", 8'h00, 8'h00, 0, 1, 1);
    @(negedge clk);
    expect_now("R7 single strobe R8", 8'h00, 8'h00, 0, 0, 0);
    mod_temp = 8'h77;
    repeat (3) @(negedge clk);
    expect_now("R10 ignored while off", 8'h00, 8'h00, 0, 0, 0);
    tx_dis_pin = 1'b0;
    @(negedge clk);
    expect_now("R3 present temp", 8'h80, 8'h77, 0, 1, 1);
    sar_run(8'h3C, 8);
    expect_now("R4 search 3C", 8'h3C, 8'h77, 1, 1, 0);

    // soft disable, both sources
    tx_dis_soft = 1'b1;
    @(negedge clk);
    expect_now("R2 soft zeroes codes", 8'h00, 8'h00, 0, 1, 1);
    tx_dis_pin = 1'b1;
    @(negedge clk);
    tx_dis_soft = 1'b0;
    @(negedge clk);
    expect_now("R2 pin still holds", 8'h00, 8'h00, 0, 0, 0);
    mod_temp = 8'h90;
    tx_dis_pin = 1'b0;
    @(negedge clk);
    expect_now("R3 release both", 8'h80, 8'h90, 0, 1, 1);

    // R6: abort mid search
    sar_run(8'h5A, 3);
    expect_now("R4 partial 5A", 8'h50, 8'h90, 0, 1, 0);
    tx_dis_pin = 1'b1;
    @(negedge clk);
    expect_now("R6 abort", 8'h00, 8'h00, 0, 1, 1);
    tx_dis_pin = 1'b0;
    @(negedge clk);
    expect_now("R3 after abort", 8'h80, 8'h90, 0, 1, 1);
    sar_run(8'h00, 8);
    expect_now("R4 target zero", 8'h00, 8'h90, 1, 1, 0);

    tx_dis_soft = 1'b1;
    @(negedge clk);
    tx_dis_soft = 1'b0;
    @(negedge clk);
    expect_now("R3 reload", 8'h80, 8'h90, 0, 1, 1);
    sar_run(8'hFF, 8);
    expect_now("R4 target full", 8'hFF, 8'h90, 1, 0, 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    report();
  end
endmodule